// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the address a synchronous RAM port uses for its array access. Every rising clock edge it samples an external address and three active-low controls (clear, load strobe and step enable) and settles on one of four actions: clear the address to zero, take the external address, advance the held address by one, or keep the held address. The chosen address sits in a register and drives the array during the cycle that follows the edge, so bursts run at one word per clock with no stall.

Clear outranks load, load outranks step, and step outranks hold. The block has no chip-enable or byte-select inputs, so a port that is deselected still loads, steps or clears as its controls ask. Stepping from the top address rolls over to zero. An asynchronous active-low system reset forces the address to zero at once. Its release is synchronised to the clock, so the controls take effect only a few edges after reset is released.

Top module: `burst_addr_ctr`

## Requirements
- R1: While the system reset `rst_n` is low, `cur_addr` is 0 without waiting for a clock edge. It stays 0 through the idle edges that follow the release of reset.
- R2: When `clr_n` is 0 at a rising edge, `cur_addr` is 0 after that edge, whatever `strobe_n`, `step_n` and `ext_addr` are.
- R3: When `clr_n` is 1 and `strobe_n` is 0 at a rising edge, `cur_addr` equals the sampled `ext_addr` after that edge.
- R4: When `clr_n` is 1 and both `strobe_n` and `step_n` are 0 at an edge, the load wins: `cur_addr` becomes `ext_addr` and not the previous value plus one.
- R5: When `clr_n` and `strobe_n` are 1 and `step_n` is 0 at an edge, `cur_addr` becomes its previous value plus one, and `ext_addr` has no effect.
- R6: When `clr_n`, `strobe_n` and `step_n` are all 1 at an edge, `cur_addr` keeps its value, and `ext_addr` has no effect.
- R7: A step from the all-ones address (0x3FFF at the default 14-bit width) gives 0.
- R8: Each edge's action shows on `cur_addr` right after that edge, with no idle cycle between actions. This holds for a clear, a load and a step in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; controls are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| ext_addr | input | ADDR_W (14) | External address that is loaded when the strobe is active |
| strobe_n | input | 1 | Active-low load strobe |
| step_n | input | 1 | Active-low step enable |
| clr_n | input | 1 | Active-low synchronous clear to address 0 |
| cur_addr | output | ADDR_W (14) | Address used by the array access in the current cycle |

## Verification
The tests drive lone loads, runs of steps and runs of holds. Each is checked against a value that differs from what the other actions would give, so a swapped or dropped action shows up. Loads and clears are applied with every other control active and with an `ext_addr` that differs from both the held value and its successor, which exposes any mistake in the priority order. A step from 0x3FFF checks the rollover. A clear, a load and steps are applied in consecutive cycles, and a reset is asserted between edges, to confirm that nothing waits a cycle.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } bac_act_e;

endpackage

// File: rtl/bac_rst_sync.sv
module bac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = 1'b1;
      end else begin : g_rest
        assign d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= d;
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic     strobe_n,
  input  logic     step_n,
  input  logic     clr_n,
  output bac_act_e act
);

  always_comb begin
    if (!clr_n)         act = ACT_CLEAR;
    else if (!strobe_n) act = ACT_LOAD;
    else if (!step_n)   act = ACT_STEP;
    else                act = ACT_HOLD;
  end

endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  bac_act_e          act,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc;

  // Full-width add: the carry out is dropped, so the top address rolls to 0.
  assign inc = cur + ONE;

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = ext_addr;
      ACT_STEP:  nxt = inc;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] cur_addr
);

  logic              rst_sync_n;
  bac_act_e          act;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;

  bac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bac_decode u_decode (
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .act      (act)
  );

  bac_next #(.ADDR_W(ADDR_W)) u_next (
    .act      (act),
    .ext_addr (ext_addr),
    .cur      (addr_q),
    .nxt      (addr_d)
  );

  // The register is enabled only when its value is to change.
  always_comb begin
    addr_en = (act != ACT_HOLD);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/bac_chk.sv
module bac_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] cur_addr
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr_n) |=> (cur_addr == '0)); // R2

  AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !strobe_n) |=> (cur_addr == $past(ext_addr))); // R3

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !strobe_n && !step_n) |=> (cur_addr == $past(ext_addr))); // R4

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && strobe_n && !step_n) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1))); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && strobe_n && step_n) |=> $stable(cur_addr)); // R6

endmodule

bind burst_addr_ctr bac_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ext_addr   (ext_addr),
  .strobe_n   (strobe_n),
  .step_n     (step_n),
  .clr_n      (clr_n),
  .cur_addr   (cur_addr)
);

// File: tb/burst_addr_ctr_tb.sv
module burst_addr_ctr_tb;

  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_n, step_n, clr_n;
  logic [AW-1:0] cur_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  burst_addr_ctr u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .cur_addr (cur_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Drive controls at the falling edge, pass one rising edge, sample 1 ns later.
  task automatic cyc(input logic clr, input logic strb, input logic stp, input logic [AW-1:0] a);
    @(negedge clk);
    clr_n = clr; strobe_n = strb; step_n = stp; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; clr_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1; ext_addr = 14'h2AAA;
    #1;
    check("R1 during reset", cur_addr, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 1, 14'h1111);
      check("R1 after release", cur_addr, '0);
    end
  endtask

  task automatic t_load;
    cyc(1, 0, 1, 14'h1234);
    check("R3 load 0x1234", cur_addr, 14'h1234);
    cyc(1, 0, 1, 14'h3FFF);
    check("R3 load 0x3FFF", cur_addr, 14'h3FFF);
  endtask

  task automatic t_step_wrap;
    cyc(1, 1, 0, 14'h0F0F);
    check("R7 wrap from 0x3FFF", cur_addr, 14'h0000);
    cyc(1, 1, 0, 14'h0F0F);
    check("R5 step to 1", cur_addr, 14'h0001);
    cyc(1, 1, 0, 14'h2222);
    check("R5 step to 2", cur_addr, 14'h0002);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 1, 14'h3A5A + 14'(i));
      check("R6 hold", cur_addr, 14'h0002);
    end
  endtask

  task automatic t_priority;
    cyc(1, 0, 0, 14'h0ABC);
    check("R4 load over step", cur_addr, 14'h0ABC);
  endtask

  task automatic t_clear;
    cyc(1, 0, 1, 14'h1555);
    check("R3 load before clear", cur_addr, 14'h1555);
    cyc(0, 0, 0, 14'h2AAA);
    check("R2 clear with all active", cur_addr, 14'h0000);
    cyc(1, 0, 1, 14'h0777);
    cyc(0, 1, 1, 14'h0777);
    check("R2 clear alone", cur_addr, 14'h0000);
  endtask

  task automatic t_no_dead;
    cyc(1, 0, 1, 14'h0100);
    check("R8 load", cur_addr, 14'h0100);
    cyc(1, 1, 0, 14'h0000);
    check("R8 step next cycle", cur_addr, 14'h0101);
    cyc(0, 1, 0, 14'h0000);
    check("R8 clear next cycle", cur_addr, 14'h0000);
    cyc(1, 1, 0, 14'h0000);
    check("R8 step after clear", cur_addr, 14'h0001);
    cyc(1, 0, 0, 14'h0200);
    check("R8 load after step", cur_addr, 14'h0200);
  endtask

  task automatic t_async_reset;
    cyc(1, 0, 1, 14'h3333);
    check("R3 load before reset", cur_addr, 14'h3333);
    @(negedge clk);
    strobe_n = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 async clear", cur_addr, 14'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after second release", cur_addr, 14'h0000);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_step_wrap();
    t_hold();
    t_priority();
    t_clear();
    t_no_dead();
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule